// File: doc/BRIEF.md
# Parallel Port Sample and Mailbox Interface

This block is the device side of a plain PC parallel port that has no usable status handshake. The host selects what the device places on the 8-bit data lines by holding two control lines at fixed levels. The choices are a sample from channel A, a sample from channel B, a one-byte mailbox, or a fixed identification byte. The device drives the data lines only while the host has its port turned around for input.

The mailbox is one byte deep and carries one message at a time in either direction. A message written by one side is visible only to the other side. The writer sees zero until the other side answers, so zero means "nothing waiting" and can never be sent. The host writes a byte by asserting two control lines and pulsing the strobe line.

Strobe pulses given while a sample channel is selected step the read address of an external sample memory. The host can then clock out a buffer one byte per pulse. The device restarts that address through its own restart input. All host control lines are asynchronous and pass through synchronizers before use.

Top module: `lpt_mbox_port`

## Requirements
- R1: After reset, the device side of the mailbox reads 0, the sample address is 0, and with both select lines inactive the bus carries channel A data at address 0.
- R2: Active-low lines `pp_nautofd` and `pp_nselectin` pick the bus source: both high gives channel A data, only `pp_nautofd` low gives channel B data, only `pp_nselectin` low gives the host view of the mailbox, and both low gives `ID_BYTE` (default 0x55).
- R3: While `pp_host_drives` is 1, `pp_data_oe` is 0. While it is 0, `pp_data_oe` is 1.
- R4: A strobe pulse (low then high) with `pp_ninit` low, `pp_nselectin` low and `pp_host_drives` at 1 stores a nonzero `pp_data_in` byte. Afterwards `mb_dev_byte` shows that byte and the host view of the mailbox reads 0.
- R5: A nonzero `mb_dev_wdata` written with `mb_dev_we` becomes the host view of the mailbox, and `mb_dev_byte` then reads 0.
- R6: A zero byte written from either side is discarded and leaves both mailbox views unchanged.
- R7: While the host view holds a nonzero device byte, a further device write is discarded, so the value does not change until the host writes.
- R8: Each strobe pulse with `pp_nselectin` high (channel A or B selected) increases `samp_addr` by one, and the bus then shows the data at the new address.
- R9: `samp_addr` wraps from `DEPTH-1` to 0 and never leaves the range 0 to `DEPTH-1`.
- R10: `rd_restart` sets `samp_addr` to 0 on the next clock and takes precedence over an advance in the same cycle.
- R11: A strobe pulse with `pp_nselectin` low and `pp_ninit` high neither writes the mailbox nor moves `samp_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pp_nstrobe | input | 1 | Host strobe line, active low |
| pp_nautofd | input | 1 | Host source-select line, active low |
| pp_ninit | input | 1 | Host mailbox-write qualifier, active low |
| pp_nselectin | input | 1 | Host source-select line, active low |
| pp_host_drives | input | 1 | 1 when the host port drives the data lines |
| pp_data_in | input | 8 | Data lines as driven by the host |
| pp_data_out | output | 8 | Data the device places on the lines |
| pp_data_oe | output | 1 | Device output enable for the data lines |
| samp_addr | output | ADDR_W | Read address to the sample memory |
| samp_a_data | input | 8 | Channel A sample at `samp_addr` |
| samp_b_data | input | 8 | Channel B sample at `samp_addr` |
| rd_restart | input | 1 | Returns the read address to 0 |
| mb_dev_byte | output | 8 | Device view of the mailbox (0 when nothing waits) |
| mb_dev_we | input | 1 | Device mailbox write strobe |
| mb_dev_wdata | input | 8 | Byte the device writes into the mailbox |

## Verification
Two events can land on the same clock edge: the host strobe advancing the read address, and the device controller asserting `rd_restart`. The bench releases the strobe and then counts the synchronizer stages, so that the restart is sampled on exactly the edge where the detected strobe rise acts. The outcome is judged on `samp_addr` and on the channel A byte placed on the bus. Address 0 is correct. The old address plus one shows the advance won.

// File: rtl/lpt_mbox_pkg.sv
package lpt_mbox_pkg;

   typedef enum logic [1:0] {
      SRC_CH_A = 2'd0,
      SRC_CH_B = 2'd1,
      SRC_MBOX = 2'd2,
      SRC_ID   = 2'd3
   } bus_src_e;

   typedef enum logic [1:0] {
      MB_EMPTY = 2'd0,
      MB_HOST  = 2'd1,
      MB_DEV   = 2'd2
   } mb_owner_e;

   typedef struct packed {
      logic strobe_n;
      logic autofd_n;
      logic init_n;
      logic selin_n;
      logic host_drives;
   } lpt_ctrl_t;

   localparam int CTRL_W = $bits(lpt_ctrl_t);

   function automatic bus_src_e pick_source(input logic autofd_n, input logic selin_n);
      case ({selin_n, autofd_n})
         2'b11:   return SRC_CH_A;
         2'b10:   return SRC_CH_B;
         2'b01:   return SRC_MBOX;
         default: return SRC_ID;
      endcase
   endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lpt_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lpt_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/lpt_sample_ptr.sv
module lpt_sample_ptr #(
   parameter int DEPTH  = 1000,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              restart,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
   localparam bit                POW2 = (DEPTH == (1 << ADDR_W));

   logic [ADDR_W-1:0] addr_next;
   logic [ADDR_W-1:0] addr_inc;

   if (POW2) begin : g_pow2_wrap
      assign addr_inc = addr + 1'b1;
   end else begin : g_cmp_wrap
      assign addr_inc = (addr == LAST) ? '0 : addr + 1'b1;
   end

   always_comb begin
      addr_next = addr;
      if (restart)      addr_next = '0;
      else if (advance) addr_next = addr_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr <= '0;
      else        addr <= addr_next;
   end

   // R9
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr <= LAST);

   // R10
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> addr == '0);

   // R8
   advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart && addr != LAST) |=> addr == $past(addr) + 1'b1);

   // R9
   advance_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart && addr == LAST) |=> addr == '0);

endmodule

// File: rtl/lpt_mbox_cell.sv
module lpt_mbox_cell
   import lpt_mbox_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_we,
   input  logic [7:0] host_wdata,
   input  logic       dev_we,
   input  logic [7:0] dev_wdata,
   output logic [7:0] host_view,
   output logic [7:0] dev_view
);

   mb_owner_e  owner;
   logic [7:0] held;
   logic       host_take;
   logic       dev_take;

   assign host_take = host_we && (host_wdata != 8'h00);
   assign dev_take  = dev_we && (dev_wdata != 8'h00) && (owner != MB_DEV) && !host_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner <= MB_EMPTY;
         held  <= 8'h00;
      end else if (host_take) begin
         owner <= MB_HOST;
         held  <= host_wdata;
      end else if (dev_take) begin
         owner <= MB_DEV;
         held  <= dev_wdata;
      end
   end

   assign host_view = (owner == MB_DEV)  ? held : 8'h00;
   assign dev_view  = (owner == MB_HOST) ? held : 8'h00;

   // R6
   held_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner != MB_EMPTY) |-> (held != 8'h00));

   // R7
   dev_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == MB_DEV && !(host_we && host_wdata != 8'h00)) |=>
         (owner == MB_DEV && $stable(held)));

   // R4
   host_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_wdata != 8'h00) |=>
         (owner == MB_HOST && held == $past(host_wdata)));

   // R5
   one_side_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_view == 8'h00) || (dev_view == 8'h00));

endmodule

// File: rtl/lpt_bus_drive.sv
module lpt_bus_drive
   import lpt_mbox_pkg::*;
#(
   parameter logic [7:0] ID_BYTE = 8'h55,
   parameter bit         OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  bus_src_e   sel,
   input  logic       host_drives,
   input  logic [7:0] ch_a,
   input  logic [7:0] ch_b,
   input  logic [7:0] mbox,
   output logic [7:0] data_out,
   output logic       data_oe
);

   logic [7:0] picked;

   always_comb begin
      case (sel)
         SRC_CH_A: picked = ch_a;
         SRC_CH_B: picked = ch_b;
         SRC_MBOX: picked = mbox;
         default:  picked = ID_BYTE;
      endcase
   end

   if (OUT_REG) begin : g_registered
      logic [7:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_q <= 8'h00;
         else        data_q <= picked;
      end
      assign data_out = data_q;

      // R2
      id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == SRC_ID) |=> data_out == ID_BYTE);
   end else begin : g_direct
      assign data_out = picked;
   end

   assign data_oe = !host_drives;

endmodule

// File: rtl/lpt_mbox_port.sv
module lpt_mbox_port
   import lpt_mbox_pkg::*;
#(
   parameter int         DEPTH       = 1000,
   parameter int         ADDR_W      = $clog2(DEPTH),
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ID_BYTE     = 8'h55,
   parameter bit         OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pp_nstrobe,
   input  logic              pp_nautofd,
   input  logic              pp_ninit,
   input  logic              pp_nselectin,
   input  logic              pp_host_drives,
   input  logic [7:0]        pp_data_in,
   output logic [7:0]        pp_data_out,
   output logic              pp_data_oe,
   output logic [ADDR_W-1:0] samp_addr,
   input  logic [7:0]        samp_a_data,
   input  logic [7:0]        samp_b_data,
   input  logic              rd_restart,
   output logic [7:0]        mb_dev_byte,
   input  logic              mb_dev_we,
   input  logic [7:0]        mb_dev_wdata
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("lpt_mbox_port: DEPTH must be at least 2");
   end
   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr_w
      $error("lpt_mbox_port: ADDR_W too narrow for DEPTH");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpt_mbox_port: SYNC_STAGES must be at least 2");
   end

   localparam lpt_ctrl_t CTRL_IDLE = '{strobe_n: 1'b1, autofd_n: 1'b1, init_n: 1'b1,
                                       selin_n: 1'b1, host_drives: 1'b1};

   lpt_ctrl_t  ctrl_raw;
   lpt_ctrl_t  ctrl_s;
   logic [7:0] data_s;
   logic       strobe_prev;
   logic       strobe_rise;
   logic       host_mb_we;
   logic       ptr_advance;
   bus_src_e   src;
   logic [7:0] mb_host_view;

   assign ctrl_raw = '{strobe_n: pp_nstrobe, autofd_n: pp_nautofd, init_n: pp_ninit,
                       selin_n: pp_nselectin, host_drives: pp_host_drives};

   lpt_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctrl_raw),
      .q     (ctrl_s)
   );

   lpt_sync #(.WIDTH(8), .STAGES(SYNC_STAGES), .RST_VAL(8'h00)) u_data_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pp_data_in),
      .q     (data_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_prev <= 1'b1;
      else        strobe_prev <= ctrl_s.strobe_n;
   end

   assign strobe_rise = ctrl_s.strobe_n && !strobe_prev;
   assign src         = pick_source(ctrl_s.autofd_n, ctrl_s.selin_n);
   assign host_mb_we  = strobe_rise && !ctrl_s.init_n && !ctrl_s.selin_n && ctrl_s.host_drives;
   assign ptr_advance = strobe_rise && ctrl_s.selin_n;

   lpt_sample_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (ptr_advance),
      .restart (rd_restart),
      .addr    (samp_addr)
   );

   lpt_mbox_cell u_mbox (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_mb_we),
      .host_wdata (data_s),
      .dev_we     (mb_dev_we),
      .dev_wdata  (mb_dev_wdata),
      .host_view  (mb_host_view),
      .dev_view   (mb_dev_byte)
   );

   lpt_bus_drive #(.ID_BYTE(ID_BYTE), .OUT_REG(OUT_REG)) u_bus (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (src),
      .host_drives (ctrl_s.host_drives),
      .ch_a        (samp_a_data),
      .ch_b        (samp_b_data),
      .mbox        (mb_host_view),
      .data_out    (pp_data_out),
      .data_oe     (pp_data_oe)
   );

   // R11
   no_side_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_rise && !ctrl_s.selin_n && ctrl_s.init_n && !rd_restart) |=>
         ($stable(samp_addr) && $stable(mb_dev_byte)));

   // R3
   drive_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_s.host_drives |-> !pp_data_oe);

endmodule

// File: tb/lpt_mbox_port_test.sv
module lpt_mbox_port_test;

   localparam int DEPTH  = 16;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              nstrobe = 1'b1, nautofd = 1'b1, ninit = 1'b1, nselin = 1'b1;
   logic              host_drives = 1'b0;
   logic [7:0]        data_in = 8'h00;
   logic [7:0]        data_out;
   logic              data_oe;
   logic [ADDR_W-1:0] addr;
   logic [7:0]        a_data, b_data;
   logic              restart = 1'b0;
   logic [7:0]        dev_byte;
   logic              dev_we = 1'b0;
   logic [7:0]        dev_wdata = 8'h00;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [7:0] mem_a(input logic [ADDR_W-1:0] a);
      return {4'h0, a} ^ 8'hA5;
   endfunction
   function automatic logic [7:0] mem_b(input logic [ADDR_W-1:0] a);
      return {4'h0, a} + 8'h30;
   endfunction

   assign a_data = mem_a(addr);
   assign b_data = mem_b(addr);

   lpt_mbox_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .pp_nstrobe     (nstrobe),
      .pp_nautofd     (nautofd),
      .pp_ninit       (ninit),
      .pp_nselectin   (nselin),
      .pp_host_drives (host_drives),
      .pp_data_in     (data_in),
      .pp_data_out    (data_out),
      .pp_data_oe     (data_oe),
      .samp_addr      (addr),
      .samp_a_data    (a_data),
      .samp_b_data    (b_data),
      .rd_restart     (restart),
      .mb_dev_byte    (dev_byte),
      .mb_dev_we      (dev_we),
      .mb_dev_wdata   (dev_wdata)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic set_ctrl(input logic afd, input logic sel, input logic ini, input logic hd);
      @(negedge clk);
      nautofd = afd; nselin = sel; ninit = ini; host_drives = hd;
      settle();
   endtask

   task automatic strobe_pulse();
      @(negedge clk); nstrobe = 1'b0;
      repeat (3) @(negedge clk);
      nstrobe = 1'b1;
      settle();
   endtask

   task automatic host_write(input logic [7:0] b);
      set_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
      data_in = b;
      strobe_pulse();
      set_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic dev_write(input logic [7:0] b);
      @(negedge clk); dev_we = 1'b1; dev_wdata = b;
      @(negedge clk); dev_we = 1'b0; dev_wdata = 8'h00;
      settle();
   endtask

   task automatic do_restart();
      @(negedge clk); restart = 1'b1;
      @(negedge clk); restart = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      settle();
      check("R1", "samp_addr", addr, 0);
      check("R1", "mb_dev_byte", dev_byte, 8'h00);
      check("R1", "bus chA", data_out, mem_a(0));
      check("R1", "oe", data_oe, 1);
   endtask

   task automatic t_decode();
      set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
      check("R2", "chB", data_out, mem_b(0));
      set_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
      check("R2", "mailbox empty", data_out, 8'h00);
      set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
      check("R2", "id byte", data_out, 8'h55);
      set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
      check("R2", "chA", data_out, mem_a(0));
   endtask

   task automatic t_tristate();
      set_ctrl(1'b1, 1'b1, 1'b1, 1'b1);
      check("R3", "oe host driving", data_oe, 0);
      set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
      check("R3", "oe device driving", data_oe, 1);
   endtask

   task automatic t_mailbox();
      host_write(8'h3C);
      check("R4", "device sees host byte", dev_byte, 8'h3C);
      check("R4", "host view empty", data_out, 8'h00);
      dev_write(8'h42);
      check("R5", "host sees reply", data_out, 8'h42);
      check("R5", "device view empty", dev_byte, 8'h00);
      dev_write(8'h77);
      check("R7", "second device write dropped", data_out, 8'h42);
      host_write(8'h00);
      check("R6", "host zero dropped host view", data_out, 8'h42);
      check("R6", "host zero dropped dev view", dev_byte, 8'h00);
      host_write(8'h11);
      check("R4", "device sees second byte", dev_byte, 8'h11);
      dev_write(8'h00);
      check("R6", "dev zero dropped dev view", dev_byte, 8'h11);
      check("R6", "dev zero dropped host view", data_out, 8'h00);
   endtask

   task automatic t_no_effect();
      set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
      data_in = 8'h99;
      strobe_pulse();
      set_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
      check("R11", "mailbox untouched", dev_byte, 8'h11);
      check("R11", "addr untouched", addr, 0);
   endtask

   task automatic t_advance();
      set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
      repeat (3) strobe_pulse();
      check("R8", "addr after 3", addr, 3);
      check("R8", "chA at 3", data_out, mem_a(3));
      set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
      strobe_pulse();
      check("R8", "addr after chB strobe", addr, 4);
      check("R8", "chB at 4", data_out, mem_b(4));
   endtask

   task automatic t_wrap();
      set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
      do_restart();
      check("R10", "restart to 0", addr, 0);
      for (int i = 0; i < DEPTH - 1; i++) strobe_pulse();
      check("R9", "addr at last", addr, DEPTH - 1);
      strobe_pulse();
      check("R9", "addr wrapped", addr, 0);
      check("R9", "chA after wrap", data_out, mem_a(0));
   endtask

   task automatic t_collision();
      set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
      repeat (5) strobe_pulse();
      check("R8", "addr before collision", addr, 5);
      @(negedge clk); nstrobe = 1'b0;
      repeat (3) @(negedge clk);
      nstrobe = 1'b1;
      @(negedge clk);
      @(negedge clk);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      settle();
      check("R10", "restart beats advance addr", addr, 0);
      check("R10", "restart beats advance bus", data_out, mem_a(0));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_decode();
      t_tristate();
      t_mailbox();
      t_no_effect();
      t_advance();
      t_wrap();
      t_collision();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule